// File: doc/BRIEF.md
# Write Buffer with Read-Miss Bypass

This block sits between a cache and main memory and holds outgoing writes (write-backs or write-throughs) in a small ring of address/data entries. It drains them to memory one at a time whenever the memory port is free. A newer write to an address that is already waiting, and not yet being offered to memory, overwrites that entry's data in place, so the ring holds fewer entries.

A read miss from the cache is checked against every waiting write in the cycle it is accepted. If an entry holds the miss address, the newest buffered word goes straight back to the cache and memory is not read. If nothing matches, the read is placed on the memory port ahead of every queued write that has not yet been offered. This removes the read-after-write hazard through memory while still letting reads jump the queue. A request already placed on the memory port stays there, unchanged, until memory accepts it.

Top module: `write_buffer_bypass`

## Requirements
- R1: While and after reset, wr_ready and rd_ready are 1 and mem_req_valid and rd_resp_valid are 0.
- R2: A write is taken on a cycle with wr_valid and wr_ready both high. wr_ready is 0 exactly when all DEPTH entries are occupied, and occupancy never exceeds DEPTH.
- R3: A write whose address matches an entry that is not currently presented on the memory port updates that entry's data and allocates no new entry.
- R4: Buffered entries reach memory as requests with mem_req_write = 1, in the order they were allocated, each carrying the newest data merged into it. Once drained, memory equals the last value written to every address.
- R5: A read accepted while an entry holds its address gets rd_resp_valid in the next cycle, for one cycle, with the youngest buffered data for that address. No memory read is issued.
- R6: A read with no matching entry is issued as a memory request with mem_req_write = 0. Its data is returned on rd_resp_data, with rd_resp_valid, in the cycle after mem_rsp_valid.
- R7: When a read is waiting for the memory port and no request is being held unaccepted, the port presents the read and not a write. The read therefore passes all queued writes not yet offered.
- R8: A request presented with mem_req_ready low stays presented, with mem_req_write, mem_req_addr and mem_req_wdata unchanged, in the next cycle.
- R9: A write taken in the same cycle as a read is ordered after that read, and the read does not observe it.
- R10: Only one read is in flight. rd_ready is 0 from the cycle after a read is accepted until after its response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Cache offers a write |
| wr_ready | output | 1 | Buffer can take a write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data word |
| rd_valid | input | 1 | Cache presents a read miss |
| rd_ready | output | 1 | Read miss can be accepted |
| rd_addr | input | ADDR_W | Read miss address |
| rd_resp_valid | output | 1 | Read data is valid this cycle |
| rd_resp_data | output | DATA_W | Read data to the cache |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data (0 on reads) |
| mem_rsp_valid | input | 1 | Memory returns read data |
| mem_rsp_data | input | DATA_W | Returned read data |

## Verification
The bench builds the block with DEPTH = 4, ADDR_W = 8 and DATA_W = 32. With four entries it is cheap to fill the ring, to hit the full stall, and to set up a merge next to a head that is locked on the memory port. A sweep confined to eight addresses makes merges, forwards and read/write conflicts frequent. With an 8-bit address, a flat 256-word reference memory and a last-written shadow copy give every expected value directly.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ISSUE = 2'd1,
        RD_WAIT  = 2'd2,
        RD_REPLY = 2'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_READ  = 2'd1,
        OWN_WRITE = 2'd2
    } port_owner_e;

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              head_lock,
    input  logic              pop,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  occ
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  head_q;
    logic [CNT_W-1:0]  count_q;

    logic [PTR_W-1:0]  slot_of [DEPTH];
    logic              live    [DEPTH];
    logic [ADDR_W-1:0] addr_at [DEPTH];
    logic [DATA_W-1:0] data_at [DEPTH];

    // age-ordered view of the ring: position 0 is the oldest entry
    for (genvar k = 0; k < DEPTH; k++) begin : g_view
        assign slot_of[k] = head_q + PTR_W'(k);
        assign live[k]    = CNT_W'(k) < count_q;
        assign addr_at[k] = addr_q[slot_of[k]];
        assign data_at[k] = data_q[slot_of[k]];
    end

    logic             merge_hit;
    logic [PTR_W-1:0] merge_slot;
    logic             alloc;
    logic [PTR_W-1:0] tail;

    always_comb begin
        merge_hit  = 1'b0;
        merge_slot = '0;
        look_hit   = 1'b0;
        look_data  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (live[k] && addr_at[k] == push_addr && !(k == 0 && head_lock)) begin
                merge_hit  = 1'b1;
                merge_slot = slot_of[k];
            end
            // later positions are younger, so the last match wins
            if (live[k] && addr_at[k] == look_addr) begin
                look_hit  = 1'b1;
                look_data = data_at[k];
            end
        end
    end

    assign alloc     = push_valid && !merge_hit;
    assign tail      = head_q + count_q[PTR_W-1:0];
    assign head_addr = addr_q[head_q];
    assign head_data = data_q[head_q];
    assign full      = count_q == CNT_W'(DEPTH);
    assign empty     = count_q == '0;
    assign occ       = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            if (pop) begin
                head_q <= head_q + 1'b1;
            end
            count_q <= count_q + CNT_W'(alloc) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push_valid) begin
            if (merge_hit) begin
                data_q[merge_slot] <= push_data;
            end else begin
                addr_q[tail] <= push_addr;
                data_q[tail] <= push_data;
            end
        end
    end

endmodule

// File: rtl/wbuf_port.sv
module wbuf_port
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_want,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_want,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_taken,
    output logic              wr_taken,
    output logic              head_lock
);

    port_owner_e held_q;
    port_owner_e pick;

    // a held request keeps the port; otherwise reads go before writes
    always_comb begin
        if (held_q != OWN_NONE) begin
            pick = held_q;
        end else if (rd_want) begin
            pick = OWN_READ;
        end else if (wr_want) begin
            pick = OWN_WRITE;
        end else begin
            pick = OWN_NONE;
        end
    end

    assign mem_valid = pick != OWN_NONE;
    assign mem_write = pick == OWN_WRITE;
    assign mem_addr  = mem_write ? wr_addr : rd_addr;
    assign mem_wdata = mem_write ? wr_data : '0;
    assign rd_taken  = mem_ready && pick == OWN_READ;
    assign wr_taken  = mem_ready && pick == OWN_WRITE;
    assign head_lock = pick == OWN_WRITE;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= OWN_NONE;
        end else if (mem_valid && !mem_ready) begin
            held_q <= pick;
        end else begin
            held_q <= OWN_NONE;
        end
    end

endmodule

// File: rtl/wbuf_read.sv
module wbuf_read
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              look_hit,
    input  logic [DATA_W-1:0] look_data,
    input  logic              taken,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              want,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data
);

    rd_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                RD_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        if (look_hit) begin
                            data_q  <= look_data;
                            state_q <= RD_REPLY;
                        end else begin
                            state_q <= RD_ISSUE;
                        end
                    end
                end
                RD_ISSUE: begin
                    if (taken) begin
                        state_q <= RD_WAIT;
                    end
                end
                RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        data_q  <= mem_rsp_data;
                        state_q <= RD_REPLY;
                    end
                end
                RD_REPLY: begin
                    state_q <= RD_IDLE;
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    assign req_ready  = state_q == RD_IDLE;
    assign want       = state_q == RD_ISSUE;
    assign pend_addr  = addr_q;
    assign resp_valid = state_q == RD_REPLY;
    assign resp_data  = data_q;

endmodule

// File: rtl/write_buffer_bypass.sv
module write_buffer_bypass #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              full;
    logic              empty;
    logic [CNT_W-1:0]  occ;
    logic              look_hit;
    logic [DATA_W-1:0] look_data;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic              head_lock;
    logic              rd_want;
    logic [ADDR_W-1:0] pend_addr;
    logic              rd_taken;
    logic              wr_taken;
    logic              push;
    logic              rd_accept;

    assign wr_ready  = !full;
    assign push      = wr_valid && wr_ready;
    assign rd_accept = rd_valid && rd_ready;

    wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_valid(push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .head_lock (head_lock),
        .pop       (wr_taken),
        .look_addr (rd_addr),
        .look_hit  (look_hit),
        .look_data (look_data),
        .head_addr (head_addr),
        .head_data (head_data),
        .full      (full),
        .empty     (empty),
        .occ       (occ)
    );

    wbuf_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_read (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (rd_accept),
        .req_addr     (rd_addr),
        .req_ready    (rd_ready),
        .look_hit     (look_hit),
        .look_data    (look_data),
        .taken        (rd_taken),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .want         (rd_want),
        .pend_addr    (pend_addr),
        .resp_valid   (rd_resp_valid),
        .resp_data    (rd_resp_data)
    );

    wbuf_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk      (clk),
        .rst      (rst),
        .rd_want  (rd_want),
        .rd_addr  (pend_addr),
        .wr_want  (!empty),
        .wr_addr  (head_addr),
        .wr_data  (head_data),
        .mem_ready(mem_req_ready),
        .mem_valid(mem_req_valid),
        .mem_write(mem_req_write),
        .mem_addr (mem_req_addr),
        .mem_wdata(mem_req_wdata),
        .rd_taken (rd_taken),
        .wr_taken (wr_taken),
        .head_lock(head_lock)
    );

endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              rd_resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic [CNT_W-1:0]  occ,
    input logic              rd_want
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH)); // R2

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH)) |-> !wr_ready); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)
             && $stable(mem_req_wdata))); // R8

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rd_want && !($past(mem_req_valid) && !$past(mem_req_ready))) |->
            (mem_req_valid && !mem_req_write)); // R7

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_resp_valid |=> !rd_resp_valid); // R5

    AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> !rd_ready); // R10

endmodule

bind write_buffer_bypass wbuf_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_ready     (wr_ready),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_resp_valid(rd_resp_valid),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .occ          (occ),
    .rd_want      (rd_want)
);

// File: tb/sim_write_buffer_bypass.sv
module sim_write_buffer_bypass;

    localparam int AW      = 8;
    localparam int DW      = 32;
    localparam int DEPTH   = 4;
    localparam int RSP_LAT = 2;
    localparam int LOG_MAX = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid = 1'b0;
    logic          rd_ready;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_resp_valid;
    logic [DW-1:0] rd_resp_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    write_buffer_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    logic [DW-1:0] shadow [256];
    logic [DW-1:0] mem_m  [256];
    int            ready_mode = 0;
    int            mem_rd_cnt = 0;
    logic          log_wr [LOG_MAX];
    logic [AW-1:0] log_a  [LOG_MAX];
    int            log_n = 0;
    logic          exp_pending = 1'b0;
    logic [DW-1:0] exp_val = '0;
    int            rsp_cd = 0;
    logic [DW-1:0] rsp_hold = '0;
    logic [15:0]   lfsr = 16'hACE1;
    string         cur_tag = "R6";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // memory model and response monitor: observe at negedge, drive after posedge
    initial begin
        for (int i = 0; i < 256; i++) begin
            shadow[i] = '0;
            mem_m[i]  = '0;
        end
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (rd_resp_valid) begin
                    check(exp_pending && rd_resp_data == exp_val, cur_tag,
                          "read response data", rd_resp_data, exp_val);
                    exp_pending = 1'b0;
                end
                if (rd_valid && rd_ready) begin
                    exp_val     = shadow[rd_addr];
                    exp_pending = 1'b1;
                end
                if (wr_valid && wr_ready) begin
                    shadow[wr_addr] = wr_data;
                end
                if (mem_req_valid && mem_req_ready) begin
                    if (log_n < LOG_MAX) begin
                        log_wr[log_n] = mem_req_write;
                        log_a[log_n]  = mem_req_addr;
                        log_n++;
                    end
                    if (mem_req_write) begin
                        mem_m[mem_req_addr] = mem_req_wdata;
                    end else begin
                        mem_rd_cnt++;
                        rsp_hold = mem_m[mem_req_addr];
                        rsp_cd   = RSP_LAT;
                    end
                end
            end
            @(posedge clk);
            #1;
            mem_rsp_valid = 1'b0;
            if (rsp_cd > 0) begin
                rsp_cd--;
                if (rsp_cd == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rsp_hold;
                end
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_req_ready = (ready_mode == 1) ? 1'b1 : (ready_mode == 2) ? lfsr[0] : 1'b0;
        end
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        do @(negedge clk); while (!wr_ready);
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic rd_issue(input logic [AW-1:0] a);
        rd_valid = 1'b1;
        rd_addr  = a;
        do @(negedge clk); while (!rd_ready);
        @(posedge clk);
        #1;
        rd_valid = 1'b0;
    endtask

    task automatic rd_wait();
        do @(negedge clk); while (!rd_resp_valid);
        @(posedge clk);
        #1;
    endtask

    // forwarded read: response must appear in the cycle right after acceptance
    task automatic rd_fwd(input logic [AW-1:0] a);
        rd_issue(a);
        @(negedge clk);
        check(rd_resp_valid == 1'b1, "R5", "forward latency", rd_resp_valid, 1);
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        do begin
            @(posedge clk);
            #1;
        end while (mem_req_valid || !rd_ready || rsp_cd != 0);
    endtask

    initial begin
        int rd0;
        step(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(wr_ready == 1'b1, "R1", "wr_ready", wr_ready, 1);
        check(rd_ready == 1'b1, "R1", "rd_ready", rd_ready, 1);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
        check(rd_resp_valid == 1'b0, "R1", "rd_resp_valid", rd_resp_valid, 0);
        @(posedge clk);
        #1;

        // memory stalled: fill, merge, and full stall
        wr(8'd10, 32'hA1);
        wr(8'd11, 32'hB1);
        wr(8'd11, 32'hB2);   // merges into entry 11 (R3)
        wr(8'd10, 32'hA2);   // head 10 is locked on the port: new entry
        @(negedge clk);
        check(wr_ready == 1'b1, "R3", "ready with 3 entries", wr_ready, 1);
        @(posedge clk);
        #1;
        wr(8'd12, 32'hC1);
        @(negedge clk);
        check(wr_ready == 1'b0, "R2", "ready when full", wr_ready, 0);
        check(mem_req_valid && mem_req_write && mem_req_addr == 8'd10, "R4",
              "head offered first", mem_req_addr, 10);
        @(posedge clk);
        #1;

        // forwarding of youngest data
        rd0 = mem_rd_cnt;
        cur_tag = "R5";
        rd_fwd(8'd11);
        rd_fwd(8'd10);
        check(mem_rd_cnt == rd0, "R5", "no memory read on forward", mem_rd_cnt, rd0);

        // read miss overtakes queued writes
        cur_tag = "R6";
        rd_issue(8'd20);
        @(negedge clk);
        check(rd_ready == 1'b0, "R10", "rd_ready after accept", rd_ready, 0);
        step(2);
        check(mem_req_valid && mem_req_write && mem_req_addr == 8'd10, "R8",
              "held write stays", mem_req_addr, 10);
        log_n = 0;
        ready_mode = 1;
        rd_wait();
        drain();
        check(log_n == 5, "R4", "transaction count", log_n, 5);
        check(log_wr[0] == 1'b1 && log_a[0] == 8'd10, "R8", "held write first", log_a[0], 10);
        check(log_wr[1] == 1'b0 && log_a[1] == 8'd20, "R7", "read overtakes", log_a[1], 20);
        check(log_wr[2] == 1'b1 && log_a[2] == 8'd11, "R4", "fifo order 2", log_a[2], 11);
        check(log_wr[3] == 1'b1 && log_a[3] == 8'd10, "R4", "fifo order 3", log_a[3], 10);
        check(log_wr[4] == 1'b1 && log_a[4] == 8'd12, "R4", "fifo order 4", log_a[4], 12);
        check(mem_m[11] == 32'hB2, "R3", "merged data drained", mem_m[11], 32'hB2);
        check(mem_m[10] == 32'hA2, "R4", "newest data in memory", mem_m[10], 32'hA2);

        // read and write to the same address in one cycle
        cur_tag = "R9";
        rd_valid = 1'b1;
        rd_addr  = 8'd30;
        wr_valid = 1'b1;
        wr_addr  = 8'd30;
        wr_data  = 32'h5EED;
        @(negedge clk);
        check(rd_ready && wr_ready, "R9", "both accepted together", {rd_ready, wr_ready}, 3);
        @(posedge clk);
        #1;
        rd_valid = 1'b0;
        wr_valid = 1'b0;
        rd_wait();
        drain();
        check(mem_m[30] == 32'h5EED, "R9", "write lands after read", mem_m[30], 32'h5EED);
        cur_tag = "R6";
        rd0 = mem_rd_cnt;
        rd_issue(8'd30);
        rd_wait();
        check(mem_rd_cnt == rd0 + 1, "R6", "miss reads memory", mem_rd_cnt, rd0 + 1);

        // near-exhaustive sweep over eight addresses with random memory stalls
        ready_mode = 2;
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [AW-1:0] a;
            op = (i * 7 + 3) % 5;
            a  = AW'((i * 13 + i / 8) % 8);
            if (op < 3) begin
                wr(a, DW'(i) * 32'h01010101 ^ 32'hA5);
            end else begin
                rd_issue(a);
                rd_wait();
            end
        end
        ready_mode = 1;
        drain();
        for (int a = 0; a < 8; a++) begin
            check(mem_m[a] == shadow[a], "R4", "memory after drain", mem_m[a], shadow[a]);
        end
        report();
    end

endmodule